// File: doc/BRIEF.md
# IDE Task-File Window Access Filter

This block sits between a host I/O port interface and the register set of one IDE channel. The host reaches the device through two windows: an 8-byte window for the data port and task-file registers, and a 4-byte control window. The block checks the offset and the size of every access and makes one of two choices. It can forward the access to the device register port with a size code. It can also handle the access itself: a read then returns all ones for the access width, and a write is dropped.

Each accepted request has one cycle of latency. The device answers a forwarded access in the same cycle in which the strobe is high. The block registers the read result, so read data appears on the host side one cycle after acceptance. Multi-byte values are little-endian: byte 0 travels on bits 7:0. The drive state machine, the base address decoding and the DMA engine are not part of this block.

Top module: `ide_taskfile_filter`

## Requirements
- R1: While reset is low, `req_ready`, `rsp_valid` and `dev_stb` are 0. `req_ready` is 1 from the second clock edge after reset is released.
- R2: In the control window (`req_ctrl`=1), only a 1-byte access (`req_size`=0) at offset 2 is forwarded. It appears as `dev_addr`=4'hC (bit 3 selects the control block and the low bits hold window offset plus 2) with `dev_size`=0.
- R3: Any other control-window access is handled locally, and this includes offsets 4 to 7. `dev_stb` stays 0. A read returns all ones of its width and a write changes nothing on the device.
- R4: In the data window, a 1-byte access at any offset 0 to 7 is forwarded with `dev_addr`={1'b0, offset} and `dev_size`=0.
- R5: In the data window, a 2-byte (`req_size`=1) or 4-byte (`req_size`=2) access at offset 0 is forwarded as a data-port transfer with `dev_addr`=0 and `dev_size` equal to `req_size`.
- R6: A 2-byte or 4-byte data-window access at a nonzero offset is handled locally. `dev_stb` stays 0, a read returns 16'hFFFF or 32'hFFFFFFFF zero-extended to 32 bits, and a write has no effect.
- R7: A read accepted at one clock edge raises `rsp_valid` for exactly the following cycle. Its data is the device read data masked to the access width, with the bytes above that width at zero. An accepted write produces no response.
- R8: A forwarded write drives `dev_wr`=1, and `dev_wdata` carries the low bytes of `req_wdata` up to the access width, with the bytes above that width at zero.
- R9: Size code 3 is never forwarded in either window. A read with size code 3 returns 32'hFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_ctrl | input | 1 | 1 = control window, 0 = data/task-file window |
| req_off | input | 3 | Byte offset within the window |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, little-endian lanes |
| rsp_valid | output | 1 | Read data valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| dev_stb | output | 1 | Device register access strobe |
| dev_wr | output | 1 | Device access is a write |
| dev_addr | output | 4 | Device register address; bit 3 selects the control block |
| dev_size | output | 2 | Device access size code |
| dev_wdata | output | 32 | Device write data |
| dev_rdata | input | 32 | Device read data, valid while strobed |

## Verification
A register-file stub stands in for the drive. Its read data carries nonzero bytes above the low byte, so a missing width mask shows up on `rsp_rdata`. Directed accesses cover every offset at every size in both windows, and they separate the single forwarded control offset from its neighbours and from offsets outside the window. Rejected wide writes are followed by byte reads of the same registers, which would show a write that leaked through. Constrained random mixes of window, offset, size, direction and data then test the decision rule against a bench model of the expected strobe and readback.

// File: rtl/ide_filt_pkg.sv
// Package: shared size codes and the width-mask helper for the IDE window filter.
// Assumes a 32-bit host and device data path with little-endian byte lanes.
package ide_filt_pkg;
    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        SZ_B1  = 2'd0,
        SZ_B2  = 2'd1,
        SZ_B4  = 2'd2,
        SZ_RSV = 2'd3
    } size_e;

    // Mask of the byte lanes that an access of the given size occupies.
    function automatic logic [BUS_W-1:0] size_mask(size_e s);
        case (s)
            SZ_B1:   size_mask = 32'h0000_00FF;
            SZ_B2:   size_mask = 32'h0000_FFFF;
            default: size_mask = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/ide_win_decode.sv
// Module: window decode. Decides from window, offset and size whether an access
// is forwarded, and forms the device address and lane mask.
// Assumes offsets are byte offsets and the control window is no larger than the data window.
module ide_win_decode
    import ide_filt_pkg::*;
#(
    parameter int DATA_WIN       = 8,
    parameter int CTRL_WIN       = 4,
    parameter int CTRL_REG_OFF   = 2,
    parameter int CTRL_ADDR_BIAS = 2
) (
    input  logic                      is_ctrl,
    input  logic [$clog2(DATA_WIN)-1:0] off,
    input  size_e                     size,
    output logic                      fwd,
    output logic [$clog2(DATA_WIN):0] dev_addr,
    output logic [BUS_W-1:0]          mask
);
    localparam int OFF_W = $clog2(DATA_WIN);
    localparam logic [OFF_W:0]   CTRL_LIMIT = (OFF_W+1)'(CTRL_WIN);
    localparam logic [OFF_W-1:0] CTRL_OFF   = OFF_W'(CTRL_REG_OFF);
    localparam logic [OFF_W-1:0] CTRL_DEV   = OFF_W'(CTRL_REG_OFF + CTRL_ADDR_BIAS);

    logic in_ctrl, ctrl_hit, data_hit;

    // Decide forwarding per window and build the device-side address.
    always_comb begin
        in_ctrl  = ({1'b0, off} < CTRL_LIMIT);
        ctrl_hit = in_ctrl && (off == CTRL_OFF) && (size == SZ_B1);
        data_hit = (size == SZ_B1) ||
                   ((off == '0) && ((size == SZ_B2) || (size == SZ_B4)));
        fwd      = is_ctrl ? ctrl_hit : data_hit;
        dev_addr = is_ctrl ? {1'b1, CTRL_DEV} : {1'b0, off};
        mask     = size_mask(size);
    end
endmodule

// File: rtl/ide_rsp_stage.sv
// Module: response stage. Registers the read result one cycle after acceptance
// and generates the host ready after reset.
// Assumes device read data is valid in the same cycle as the strobe.
module ide_rsp_stage
    import ide_filt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_rd,
    input  logic             fwd,
    input  logic [BUS_W-1:0] mask,
    input  logic [BUS_W-1:0] dev_rdata,
    output logic             ready,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata
);
    // Raise ready one cycle after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) ready <= 1'b0;
        else        ready <= 1'b1;
    end

    // Capture the masked device data or the all-ones local value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= accept_rd;
            if (accept_rd) rsp_rdata <= fwd ? (dev_rdata & mask) : mask;
        end
    end

    assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid || $past(accept_rd)));
    assert_rsp_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_rd && !fwd) |=> (rsp_rdata == $past(mask)));
endmodule

// File: rtl/ide_taskfile_filter.sv
// Module: top of the IDE window access filter for one channel.
// Forwards legal accesses to the device register port and answers all others
// locally with all ones (reads) or by dropping them (writes).
// Assumes a 32-bit bus with little-endian lanes and a device that answers in the strobe cycle.
module ide_taskfile_filter
    import ide_filt_pkg::*;
#(
    parameter int DATA_WIN       = 8,
    parameter int CTRL_WIN       = 4,
    parameter int CTRL_REG_OFF   = 2,
    parameter int CTRL_ADDR_BIAS = 2,
    localparam int OFF_W         = $clog2(DATA_WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_ctrl,
    input  logic [OFF_W-1:0] req_off,
    input  logic [1:0]       req_size,
    input  logic             req_wr,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata,
    output logic             dev_stb,
    output logic             dev_wr,
    output logic [OFF_W:0]   dev_addr,
    output logic [1:0]       dev_size,
    output logic [BUS_W-1:0] dev_wdata,
    input  logic [BUS_W-1:0] dev_rdata
);
    logic             fwd;
    logic [BUS_W-1:0] mask;
    logic             accept;

    ide_win_decode #(
        .DATA_WIN(DATA_WIN), .CTRL_WIN(CTRL_WIN),
        .CTRL_REG_OFF(CTRL_REG_OFF), .CTRL_ADDR_BIAS(CTRL_ADDR_BIAS)
    ) u_dec (
        .is_ctrl(req_ctrl), .off(req_off), .size(size_e'(req_size)),
        .fwd(fwd), .dev_addr(dev_addr), .mask(mask)
    );

    ide_rsp_stage u_rsp (
        .clk(clk), .rst_n(rst_n), .accept_rd(accept && !req_wr),
        .fwd(fwd), .mask(mask), .dev_rdata(dev_rdata),
        .ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // Drive the device strobe and the masked write lanes for a forwarded access.
    always_comb begin
        accept    = req_valid && req_ready;
        dev_stb   = accept && fwd;
        dev_wr    = req_wr;
        dev_size  = req_size;
        dev_wdata = req_wdata & mask;
    end

    assert_ctrl_only_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ctrl && !(req_off == OFF_W'(CTRL_REG_OFF) && req_size == 2'd0))
        |-> !dev_stb);
    assert_wide_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_stb && dev_size != 2'd0) |-> (dev_addr == '0));
    assert_no_rsv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_stb |-> (dev_size != 2'd3));
    assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_wr) |=> rsp_valid);
    assert_write_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_wr) |=> !rsp_valid);
endmodule

// File: tb/tb_ide_taskfile_filter.sv
`timescale 1ns/1ps
module tb_ide_taskfile_filter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ctrl = 1'b0, req_wr = 1'b0;
    logic [2:0] req_off = '0;
    logic [1:0] req_size = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready, rsp_valid, dev_stb, dev_wr;
    logic [31:0] rsp_rdata, dev_wdata, dev_rdata;
    logic [3:0] dev_addr;
    logic [1:0] dev_size;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ide_taskfile_filter dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_ctrl(req_ctrl), .req_off(req_off), .req_size(req_size), .req_wr(req_wr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .dev_stb(dev_stb), .dev_wr(dev_wr), .dev_addr(dev_addr), .dev_size(dev_size),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    // Drive stub: task-file bytes, a control byte and a data-port word.
    logic [7:0]  tf [8];
    logic [7:0]  ctl_reg;
    logic [31:0] dport;

    always_comb begin
        if (dev_addr == 4'hC)                         dev_rdata = {24'hA5A5A5, ctl_reg};
        else if (dev_size != 2'd0)                    dev_rdata = dport;
        else                                          dev_rdata = {24'h5A5A5A, tf[dev_addr[2:0]]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) tf[i] <= 8'(i * 17 + 3);
            ctl_reg <= 8'h50;
            dport   <= 32'h1234_5678;
        end else if (dev_stb && dev_wr) begin
            if (dev_addr == 4'hC)       ctl_reg <= dev_wdata[7:0];
            else if (dev_size != 2'd0)  dport <= dev_wdata;
            else                        tf[dev_addr[2:0]] <= dev_wdata[7:0];
        end
    end

    // Bench mirror of the stub contents.
    logic [7:0]  m_tf [8];
    logic [7:0]  m_ctl;
    logic [31:0] m_dp;

    function automatic logic [31:0] wmask(logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic bit exp_fwd(logic c, logic [2:0] o, logic [1:0] s);
        if (c) return (o == 3'd2) && (s == 2'd0);
        return (s == 2'd0) || (o == 3'd0 && (s == 2'd1 || s == 2'd2));
    endfunction

    function automatic logic [3:0] exp_addr(logic c, logic [2:0] o);
        return c ? 4'hC : {1'b0, o};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(logic c, logic [2:0] o, logic [1:0] s);
        if (s == 2'd3) return "R9";
        if (c) return exp_fwd(c, o, s) ? "R2" : "R3";
        if (s == 2'd0) return "R4";
        return (o == 3'd0) ? "R5" : "R6";
    endfunction

    task automatic access(logic c, logic [2:0] o, logic [1:0] s, logic w, logic [31:0] d);
        bit f;
        logic [31:0] exp;
        string r;
        f = exp_fwd(c, o, s);
        r = req_of(c, o, s);
        @(negedge clk);
        req_valid = 1'b1; req_ctrl = c; req_off = o; req_size = s; req_wr = w; req_wdata = d;
        #1;
        chk(dev_stb == f, r, 32'(dev_stb), 32'(f));
        if (f) begin
            chk(dev_addr == exp_addr(c, o) && dev_size == s, r,
                {24'h0, dev_addr, 2'b0, dev_size}, {24'h0, exp_addr(c, o), 2'b0, s});
            if (w) chk(dev_wr && dev_wdata == (d & wmask(s)), "R8", dev_wdata, d & wmask(s));
        end
        if (f) begin
            if (!c && s == 2'd0) exp = {24'h5A5A5A, m_tf[o]} & wmask(s);
            else if (c)          exp = {24'hA5A5A5, m_ctl} & wmask(s);
            else                 exp = m_dp & wmask(s);
        end else exp = wmask(s);
        if (f && w) begin
            if (c)               m_ctl = d[7:0];
            else if (s == 2'd0)  m_tf[o] = d[7:0];
            else                 m_dp = d & wmask(s);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == !w, "R7", 32'(rsp_valid), 32'(!w));
        if (!w) chk(rsp_rdata == exp, r, rsp_rdata, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) m_tf[i] = 8'(i * 17 + 3);
        m_ctl = 8'h50; m_dp = 32'h1234_5678;
        // R1: reset state with a forwardable request held up.
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_ctrl = 1'b0; req_off = 3'd1; req_size = 2'd0; req_wr = 1'b0;
        #1;
        chk(!req_ready && !rsp_valid && !dev_stb, "R1",
            {29'h0, req_ready, rsp_valid, dev_stb}, 32'h0);
        req_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(req_ready && !rsp_valid, "R1", {30'h0, req_ready, rsp_valid}, 32'h2);

        // Directed sweep: every offset and size in both windows, reads.
        for (int c = 0; c < 2; c++)
            for (int o = 0; o < 8; o++)
                for (int s = 0; s < 4; s++)
                    access(c[0], 3'(o), 2'(s), 1'b0, 32'h0);

        // R3 / R6: rejected writes, then byte readback shows no change.
        access(1'b1, 3'd0, 2'd0, 1'b1, 32'h77);
        access(1'b1, 3'd2, 2'd1, 1'b1, 32'hBEEF);
        access(1'b1, 3'd2, 2'd0, 1'b0, 0);
        access(1'b0, 3'd3, 2'd1, 1'b1, 32'hCAFE);
        access(1'b0, 3'd4, 2'd2, 1'b1, 32'hDEAD_BEEF);
        access(1'b0, 3'd3, 2'd0, 1'b0, 0);
        access(1'b0, 3'd4, 2'd0, 1'b0, 0);
        // R9: reserved size write in data window at offset 0.
        access(1'b0, 3'd0, 2'd3, 1'b1, 32'h1111_2222);
        access(1'b0, 3'd0, 2'd2, 1'b0, 0);
        // R2 / R4 / R5 / R8: forwarded writes then readback.
        access(1'b1, 3'd2, 2'd0, 1'b1, 32'hFFFF_FF0A);
        access(1'b1, 3'd2, 2'd0, 1'b0, 0);
        access(1'b0, 3'd0, 2'd1, 1'b1, 32'hABCD_9876);
        access(1'b0, 3'd0, 2'd2, 1'b0, 0);
        access(1'b0, 3'd0, 2'd2, 1'b1, 32'hF00D_FACE);
        access(1'b0, 3'd0, 2'd1, 1'b0, 0);
        access(1'b0, 3'd7, 2'd0, 1'b1, 32'h1234_56C3);
        access(1'b0, 3'd7, 2'd0, 1'b0, 0);

        // Constrained random mix.
        for (int n = 0; n < 400; n++) begin
            logic c; logic [2:0] o; logic [1:0] s;
            c = ($urandom_range(0, 3) == 0);
            o = ($urandom_range(0, 2) == 0) ? 3'd0 : 3'($urandom_range(0, 7));
            if (c && $urandom_range(0, 1) == 1) o = 3'd2;
            s = 2'($urandom_range(0, 3));
            access(c, o, s, 1'($urandom_range(0, 1)), $urandom);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule